// File: doc/BRIEF.md
# PS/2 Keyboard Key-Event Decoder

This block listens to the two wires of a PS/2 keyboard: a clock driven by the keyboard and a data line. Both wires are asynchronous to the system clock. The block synchronises both lines and removes short glitches from the clock line. It then assembles and checks the 11-bit frames and folds the stream of received bytes into whole key events. Each event gives the key's scan code, whether the key went down or came up, and whether the key belongs to the extended set.

Prefix bytes are absorbed and never reported as keys. The byte 0xF0 marks the next code as a key-up. The byte 0xE0 marks it as extended. The two-byte sequence 0xE0, 0xF0 marks it as both. Frames with a bad start, stop or parity bit raise a one-cycle error strobe and clear any pending prefix. A frame that stalls part-way is abandoned after a silence window, so the receiver never hangs. The default parameters assume a 50 MHz system clock.

Top module: `ps2_key_decoder`

## Requirements
- R1: After reset, `key_valid_o`, `key_code_o`, `key_release_o`, `key_ext_o` and `frame_err_o` are all 0.
- R2: A frame is a 0 start bit, then 8 data bits least significant first, then a parity bit, then a 1 stop bit, with each bit taken on a falling edge of the PS/2 clock. A valid frame carrying a code other than 0xE0 or 0xF0, with no prefix pending, gives exactly one cycle of `key_valid_o` with that code on `key_code_o` and both flags at 0. Outside that cycle the code and both flags read 0.
- R3: A received 0xF0 produces no event. The next code is reported with `key_release_o`=1 and `key_ext_o`=0, and the flag is cleared once that event has been emitted.
- R4: A received 0xE0 produces no event. The next code is reported with `key_ext_o`=1 and `key_release_o`=0, and the flag is cleared once that event has been emitted.
- R5: The sequence 0xE0, 0xF0, code produces a single event with both `key_ext_o` and `key_release_o` at 1.
- R6: Repeated identical make codes each produce their own press event. No repeat is suppressed.
- R7: A frame whose data and parity bits together hold an even number of ones produces a one-cycle `frame_err_o` pulse and no event. It also clears any pending release or extended prefix.
- R8: A frame with a start bit of 1 or a stop bit of 0 produces a one-cycle `frame_err_o` pulse and no event.
- R9: A frame is abandoned without an error pulse if no clock falling edge arrives within `TIMEOUT_US` microseconds (5000 system cycles with the defaults). The next complete frame then decodes correctly.
- R10: A low pulse on the PS/2 clock shorter than `FILT_LEN` system cycles (8 by default) is ignored and does not shift a bit in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ps2_clk_i | input | 1 | PS/2 clock line, asynchronous |
| ps2_dat_i | input | 1 | PS/2 data line, asynchronous |
| key_valid_o | output | 1 | One-cycle key event strobe |
| key_code_o | output | 8 | Scan code of the event |
| key_release_o | output | 1 | Event is a key-up |
| key_ext_o | output | 1 | Event is an extended key |
| frame_err_o | output | 1 | One-cycle framing or parity error strobe |

## Verification
Plain make codes are sent with several bit patterns, including one dominated by ones and one dominated by zeros, to separate least-significant-first assembly and parity handling from a fixed pattern. The prefix cases cover a single key-up prefix, a single extended prefix, and the double prefix followed by a plain code. Together they show whether each flag is set by the right byte and cleared after its event. Corrupted parity, start and stop bits are each sent, one after a pending prefix to show that the error clears it. A truncated frame followed by silence shows recovery by timeout, and sub-threshold clock glitches show that the filter keeps bit alignment.

// File: rtl/ps2_kbd_pkg.sv
package ps2_kbd_pkg;

    localparam logic [7:0] CODE_BREAK = 8'hF0;
    localparam logic [7:0] CODE_EXT   = 8'hE0;
    localparam int unsigned FRAME_BITS = 11;

    typedef struct packed {
        logic       valid;
        logic [7:0] code;
        logic       rel;
        logic       ext;
    } key_evt_t;

endpackage

// File: rtl/ps2_line_cond.sv
module ps2_line_cond #(
    parameter int unsigned FILT_LEN = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ps2_clk_i,
    input  logic ps2_dat_i,
    output logic fall_o,
    output logic dat_o
);

    localparam int unsigned CW = $clog2(FILT_LEN + 1);
    localparam logic [CW-1:0] CNT_LAST = CW'(FILT_LEN - 1);

    // bit 1: clock line, bit 0: data line
    typedef struct packed {
        logic [1:0]    meta;
        logic [1:0]    sync;
        logic          filt;
        logic [CW-1:0] cnt;
        logic          fall;
    } cond_t;

    cond_t cond_d, cond_q;

    always_comb begin
        cond_d      = cond_q;
        cond_d.meta = {ps2_clk_i, ps2_dat_i};
        cond_d.sync = cond_q.meta;
        cond_d.fall = 1'b0;
        if (cond_q.sync[1] == cond_q.filt) begin
            cond_d.cnt = '0;
        end else if (cond_q.cnt == CNT_LAST) begin
            cond_d.cnt  = '0;
            cond_d.filt = cond_q.sync[1];
            cond_d.fall = cond_q.filt & ~cond_q.sync[1];
        end else begin
            cond_d.cnt = cond_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cond_q.meta <= 2'b11;
            cond_q.sync <= 2'b11;
            cond_q.filt <= 1'b1;
            cond_q.cnt  <= '0;
            cond_q.fall <= 1'b0;
        end else begin
            cond_q <= cond_d;
        end
    end

    assign fall_o = cond_q.fall;
    assign dat_o  = cond_q.sync[0];

endmodule

// File: rtl/ps2_frame_rx.sv
module ps2_frame_rx
    import ps2_kbd_pkg::*;
#(
    parameter int unsigned TIMEOUT_CYC = 5000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       fall_i,
    input  logic       dat_i,
    output logic       byte_vld_o,
    output logic [7:0] byte_o,
    output logic       err_o
);

    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);
    localparam logic [TW-1:0] TMO_LAST = TW'(TIMEOUT_CYC - 1);
    localparam logic [3:0] BIT_LAST = 4'(FRAME_BITS - 1);

    typedef struct packed {
        logic                  busy;
        logic [3:0]            cnt;
        logic [FRAME_BITS-1:0] sh;
        logic [TW-1:0]         tmo;
        logic                  vld;
        logic                  err;
        logic [7:0]            data;
    } rx_t;

    rx_t rx_d, rx_q;
    logic [FRAME_BITS-1:0] sh_next;

    always_comb begin
        rx_d     = rx_q;
        rx_d.vld = 1'b0;
        rx_d.err = 1'b0;
        sh_next  = {dat_i, rx_q.sh[FRAME_BITS-1:1]};
        if (fall_i) begin
            rx_d.sh  = sh_next;
            rx_d.tmo = '0;
            if (!rx_q.busy) begin
                rx_d.busy = 1'b1;
                rx_d.cnt  = 4'd1;
            end else if (rx_q.cnt == BIT_LAST) begin
                rx_d.busy = 1'b0;
                rx_d.cnt  = '0;
                if (!sh_next[0] && sh_next[FRAME_BITS-1] && (^sh_next[9:1])) begin
                    rx_d.vld  = 1'b1;
                    rx_d.data = sh_next[8:1];
                end else begin
                    rx_d.err = 1'b1;
                end
            end else begin
                rx_d.cnt = rx_q.cnt + 4'd1;
            end
        end else if (rx_q.busy) begin
            if (rx_q.tmo == TMO_LAST) begin
                rx_d.busy = 1'b0;
                rx_d.cnt  = '0;
                rx_d.tmo  = '0;
            end else begin
                rx_d.tmo = rx_q.tmo + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign byte_vld_o = rx_q.vld;
    assign byte_o     = rx_q.data;
    assign err_o      = rx_q.err;

endmodule

// File: rtl/ps2_event_fsm.sv
module ps2_event_fsm
    import ps2_kbd_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     byte_vld_i,
    input  logic [7:0] byte_i,
    input  logic     err_i,
    output key_evt_t evt_o
);

    typedef struct packed {
        logic     rel;
        logic     ext;
        key_evt_t evt;
    } ev_t;

    ev_t ev_d, ev_q;

    always_comb begin
        ev_d     = ev_q;
        ev_d.evt = '0;
        if (err_i) begin
            ev_d.rel = 1'b0;
            ev_d.ext = 1'b0;
        end else if (byte_vld_i) begin
            if (byte_i == CODE_BREAK) begin
                ev_d.rel = 1'b1;
            end else if (byte_i == CODE_EXT) begin
                ev_d.ext = 1'b1;
            end else begin
                ev_d.evt.valid = 1'b1;
                ev_d.evt.code  = byte_i;
                ev_d.evt.rel   = ev_q.rel;
                ev_d.evt.ext   = ev_q.ext;
                ev_d.rel       = 1'b0;
                ev_d.ext       = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= ev_d;
        end
    end

    assign evt_o = ev_q.evt;

endmodule

// File: rtl/ps2_key_decoder.sv
module ps2_key_decoder
    import ps2_kbd_pkg::*;
#(
    parameter int unsigned CLK_HZ     = 50_000_000,
    parameter int unsigned TIMEOUT_US = 100,
    parameter int unsigned FILT_LEN   = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ps2_clk_i,
    input  logic       ps2_dat_i,
    output logic       key_valid_o,
    output logic [7:0] key_code_o,
    output logic       key_release_o,
    output logic       key_ext_o,
    output logic       frame_err_o
);

    localparam int unsigned TIMEOUT_CYC = (CLK_HZ / 1_000_000) * TIMEOUT_US;

    logic       fall;
    logic       dat;
    logic       byte_vld;
    logic [7:0] byte_val;
    logic       err;
    key_evt_t   evt;

    ps2_line_cond #(
        .FILT_LEN (FILT_LEN)
    ) u_cond (
        .clk       (clk),
        .rst_n     (rst_n),
        .ps2_clk_i (ps2_clk_i),
        .ps2_dat_i (ps2_dat_i),
        .fall_o    (fall),
        .dat_o     (dat)
    );

    ps2_frame_rx #(
        .TIMEOUT_CYC (TIMEOUT_CYC)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .fall_i     (fall),
        .dat_i      (dat),
        .byte_vld_o (byte_vld),
        .byte_o     (byte_val),
        .err_o      (err)
    );

    ps2_event_fsm u_evt (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld_i (byte_vld),
        .byte_i     (byte_val),
        .err_i      (err),
        .evt_o      (evt)
    );

    assign key_valid_o   = evt.valid;
    assign key_code_o    = evt.code;
    assign key_release_o = evt.rel;
    assign key_ext_o     = evt.ext;
    assign frame_err_o   = err;

endmodule

// File: rtl/ps2_key_decoder_chk.sv
module ps2_key_decoder_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       key_valid_o,
    input logic [7:0] key_code_o,
    input logic       key_release_o,
    input logic       key_ext_o,
    input logic       frame_err_o
);

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |=> !key_valid_o); // R2

    AST_FIELDS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid_o |-> (key_code_o == 8'h00 && !key_release_o && !key_ext_o)); // R2

    AST_NO_PREFIX_CODE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid_o |-> (key_code_o != 8'hF0 && key_code_o != 8'hE0)); // R3

    AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !frame_err_o); // R7

    AST_ERR_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err_o |=> !key_valid_o); // R7

endmodule

bind ps2_key_decoder ps2_key_decoder_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .key_valid_o   (key_valid_o),
    .key_code_o    (key_code_o),
    .key_release_o (key_release_o),
    .key_ext_o     (key_ext_o),
    .frame_err_o   (frame_err_o)
);

// File: tb/ps2_key_decoder_tb.sv
`timescale 1ns/1ps
module ps2_key_decoder_tb;

    localparam int HALF = 40;    // PS/2 half period in system cycles
    localparam int GAP  = 150;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ps2_clk = 1'b1;
    logic       ps2_dat = 1'b1;
    logic       key_valid;
    logic [7:0] key_code;
    logic       key_rel;
    logic       key_ext;
    logic       frame_err;

    int n_chk = 0;
    int n_fail = 0;
    int ev_cnt = 0;
    int err_cnt = 0;
    logic [7:0] last_code = 8'h00;
    logic       last_rel = 1'b0;
    logic       last_ext = 1'b0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    ps2_key_decoder u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .ps2_clk_i     (ps2_clk),
        .ps2_dat_i     (ps2_dat),
        .key_valid_o   (key_valid),
        .key_code_o    (key_code),
        .key_release_o (key_rel),
        .key_ext_o     (key_ext),
        .frame_err_o   (frame_err)
    );

    always @(negedge clk) begin
        if (rst_n && key_valid) begin
            ev_cnt    <= ev_cnt + 1;
            last_code <= key_code;
            last_rel  <= key_rel;
            last_ext  <= key_ext;
        end
        if (rst_n && frame_err) err_cnt <= err_cnt + 1;
    end

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send_bits(input logic [10:0] bits, input int nbits);
        for (int i = 0; i < nbits; i++) begin
            ps2_dat = bits[i];
            tick(HALF / 2);
            ps2_clk = 1'b0;
            tick(HALF);
            ps2_clk = 1'b1;
            tick(HALF / 2);
        end
        ps2_dat = 1'b1;
    endtask

    task automatic frame(input logic [7:0] b, input bit bad_par,
                         input bit bad_start, input bit bad_stop);
        logic par;
        par = (~^b) ^ bad_par;
        send_bits({~bad_stop, par, b, bad_start}, 11);
        tick(GAP);
    endtask

    task automatic send(input logic [7:0] b);
        frame(b, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic expect_evt(input string req, input int base, input logic [7:0] code,
                              input logic rel, input logic ext);
        chk(ev_cnt == base + 1, req, "event count", ev_cnt, base + 1);
        chk(last_code == code, req, "code", last_code, code);
        chk(last_rel == rel, req, "release flag", last_rel, rel);
        chk(last_ext == ext, req, "extended flag", last_ext, ext);
    endtask

    task automatic t_reset();
        // R1
        chk(!key_valid && !frame_err, "R1", "strobes after reset",
            {key_valid, frame_err}, 0);
        chk(key_code == 8'h00 && !key_rel && !key_ext, "R1", "fields after reset",
            {key_rel, key_ext, key_code}, 0);
    endtask

    task automatic t_make();
        logic [7:0] codes [3] = '{8'h1C, 8'hFE, 8'h01};
        for (int i = 0; i < 3; i++) begin
            int base = ev_cnt;
            send(codes[i]);
            expect_evt("R2", base, codes[i], 1'b0, 1'b0);
        end
        chk(err_cnt == 0, "R2", "no error on good frames", err_cnt, 0);
    endtask

    task automatic t_release();
        int base = ev_cnt;
        send(8'hF0);
        chk(ev_cnt == base, "R3", "prefix gives no event", ev_cnt, base);
        send(8'h1C);
        expect_evt("R3", base, 8'h1C, 1'b1, 1'b0);
        base = ev_cnt;
        send(8'h1C);
        expect_evt("R3", base, 8'h1C, 1'b0, 1'b0);
    endtask

    task automatic t_ext();
        int base = ev_cnt;
        send(8'hE0);
        chk(ev_cnt == base, "R4", "prefix gives no event", ev_cnt, base);
        send(8'h75);
        expect_evt("R4", base, 8'h75, 1'b0, 1'b1);
        base = ev_cnt;
        send(8'h75);
        expect_evt("R4", base, 8'h75, 1'b0, 1'b0);
    endtask

    task automatic t_ext_rel();
        int base = ev_cnt;
        send(8'hE0);
        send(8'hF0);
        chk(ev_cnt == base, "R5", "double prefix gives no event", ev_cnt, base);
        send(8'h6B);
        expect_evt("R5", base, 8'h6B, 1'b1, 1'b1);
    endtask

    task automatic t_repeat();
        int base = ev_cnt;
        for (int i = 0; i < 3; i++) send(8'h2B);
        chk(ev_cnt == base + 3, "R6", "repeat count", ev_cnt, base + 3);
        chk(last_code == 8'h2B && !last_rel && !last_ext, "R6", "repeat fields",
            {last_rel, last_ext, last_code}, 8'h2B);
    endtask

    task automatic t_parity();
        int base = ev_cnt;
        int ebase = err_cnt;
        send(8'hF0);
        frame(8'h33, 1'b1, 1'b0, 1'b0);
        chk(err_cnt == ebase + 1, "R7", "parity error pulse", err_cnt, ebase + 1);
        chk(ev_cnt == base, "R7", "no event on parity error", ev_cnt, base);
        send(8'h33);
        expect_evt("R7", base, 8'h33, 1'b0, 1'b0);
    endtask

    task automatic t_framing();
        int base = ev_cnt;
        int ebase = err_cnt;
        frame(8'h44, 1'b0, 1'b0, 1'b1);
        chk(err_cnt == ebase + 1, "R8", "stop bit error", err_cnt, ebase + 1);
        frame(8'h44, 1'b0, 1'b1, 1'b0);
        chk(err_cnt == ebase + 2, "R8", "start bit error", err_cnt, ebase + 2);
        chk(ev_cnt == base, "R8", "no event on framing error", ev_cnt, base);
    endtask

    task automatic t_timeout();
        int base = ev_cnt;
        int ebase = err_cnt;
        send_bits(11'b000_0000_1010, 4);
        tick(6000);
        send(8'h29);
        expect_evt("R9", base, 8'h29, 1'b0, 1'b0);
        chk(err_cnt == ebase, "R9", "no error after abandon", err_cnt, ebase);
    endtask

    task automatic t_glitch();
        int base = ev_cnt;
        int ebase = err_cnt;
        for (int i = 0; i < 3; i++) begin
            ps2_clk = 1'b0;
            tick(3);
            ps2_clk = 1'b1;
            tick(20);
        end
        send(8'h4D);
        expect_evt("R10", base, 8'h4D, 1'b0, 1'b0);
        chk(err_cnt == ebase, "R10", "no error from glitches", err_cnt, ebase);
    endtask

    initial begin
        tick(10);
        rst_n = 1'b1;
        tick(20);
        t_reset();
        t_make();
        t_release();
        t_ext();
        t_ext_rel();
        t_repeat();
        t_parity();
        t_framing();
        t_timeout();
        t_glitch();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        tick(150000);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule